// File: doc/BRIEF.md
# Page-Mode Read Controller for Asynchronous Pseudo-Static Memory

This block sits between an on-chip requester and an external asynchronous pseudo-static memory. It takes a read request (start word address, number of words minus one, and a flag that allows page reads) and fetches the words one by one. It streams each word back with a valid strobe and marks the final word with a last flag. The first word after chip enable falls always costs a full random access. When page reads are allowed, the following words of the same 16-word page are fetched by stepping only the four low address bits. Each such word costs the shorter page access time.

Chip enable may not stay low for long, because the memory needs that idle time for its own refresh. The controller therefore keeps a count of chip-enable-low cycles. If the next page word would push that count past a programmable ceiling, it raises chip enable for one cycle and continues with a fresh random access. A request that runs past the end of a page is split in the same way. The memory clock pin stays static, the write strobe stays inactive, and the memory's wait output is not used.

Top module: `apsram_page_reader`

## Requirements
- R1: While `mem_ce_n` stays low, `mem_addr` bits from bit 4 upward do not change; each page-mode word advances `mem_addr[3:0]` by one.
- R2: The first word of an access is captured T_RAND cycles after the clock edge that accepts the request (or that ends the one-cycle chip-enable-high gap), and `rd_valid` is high in the cycle after that capture edge.
- R3: With page reads allowed, later words of the same page follow each other at T_PAGE-cycle spacing with `mem_ce_n` held low.
- R4: With `req_page_en` = 0, every word is a separate random access: `mem_ce_n` goes high for one cycle between words, so the spacing is T_RAND+1 cycles.
- R5: Whenever `mem_ce_n` is low, `mem_adv_n`, `mem_oe_n` and both bits of `mem_bw_n` are low. `mem_we_n` is always 1 and `mem_clk` is always 0.
- R6: In the cycle where the last word's `rd_valid` is high, `mem_ce_n` is high and `req_ready` is 1.
- R7: `mem_wait` has no effect: toggling it leaves word timing and data unchanged.
- R8: Given `cfg_ce_max` >= T_RAND, `mem_ce_n` is never low for more than `cfg_ce_max` consecutive cycles. A page word that would not fit is fetched after a one-cycle gap, with a new random access.
- R9: A request that continues past a word address whose bits [3:0] are 4'hF is split: a one-cycle gap follows, then a random access at the next address.
- R10: Exactly `req_words_m1`+1 words are returned, each carrying the memory data for its address in increasing address order. `rd_last` is high only together with the final `rd_valid`.
- R11: During and after reset: `mem_ce_n` = 1, `mem_oe_n` = 1, `rd_valid` = 0, `req_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ce_max | input | CW (12) | Largest allowed run of chip-enable-low cycles |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Controller idle, request accepted on this edge |
| req_addr | input | AW (23) | Start word address |
| req_words_m1 | input | LW (8) | Number of words minus one |
| req_page_en | input | 1 | Allow page-mode reads for this request |
| rd_valid | output | 1 | One-cycle strobe per returned word |
| rd_last | output | 1 | Final word of the request |
| rd_data | output | DW (16) | Returned word |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low, held high |
| mem_bw_n | output | 2 | Byte lane enables, active low |
| mem_clk | output | 1 | Memory clock, held static low |
| mem_addr | output | AW (23) | Memory word address |
| mem_dq_in | input | DW (16) | Read data from memory |
| mem_wait | input | 1 | Memory wait output, not used |

## Verification
Each word is captured a fixed number of cycles after the edge that begins its interval. That is T_RAND cycles after acceptance or after a gap, and T_PAGE cycles after the previous page word. `rd_valid` then shows in the following cycle. The bench stamps every `rd_valid` with its cycle offset from the accepting edge, sampling at the falling clock edge. It then compares the stamps against a timeline computed from the requirements: page boundary, page enable and the chip-enable ceiling together decide whether each step costs T_PAGE or T_RAND+1. Chip-enable run lengths and strobe levels are watched every cycle and checked once per scenario.

// File: rtl/apr_pkg.sv
package apr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RAND = 2'd1,
    ST_PAGE = 2'd2,
    ST_GAP  = 2'd3
  } apr_state_e;
endpackage

// File: rtl/apr_reset_sync.sv
module apr_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/apr_interval_timer.sv
// Counts one access interval; expire marks the capture edge.
module apr_interval_timer #(
  parameter int T_RAND = 7,
  parameter int T_PAGE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_rand,
  input  logic start_page,
  output logic expire
);
  localparam int MAXT = (T_RAND > T_PAGE) ? T_RAND : T_PAGE;
  localparam int TW   = (MAXT < 2) ? 1 : $clog2(MAXT);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;

  assign expire = run_q && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (start_rand) begin
      cnt_d = TW'(T_RAND - 1);
      run_d = 1'b1;
    end else if (start_page) begin
      cnt_d = TW'(T_PAGE - 1);
      run_d = 1'b1;
    end else if (expire) begin
      run_d = 1'b0;
    end else if (run_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end
endmodule

// File: rtl/apr_addr_gen.sv
// Holds the current word address and the words still owed.
module apr_addr_gen #(
  parameter int AW = 23,
  parameter int LW = 8,
  parameter int PB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] words_m1,
  output logic [AW-1:0] addr,
  output logic          last_word,
  output logic          next_in_page
);
  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] left_q, left_d;

  always_comb begin
    addr_d = addr_q;
    left_d = left_q;
    if (load) begin
      addr_d = start_addr;
      left_d = words_m1;
    end else if (step) begin
      addr_d = addr_q + 1'b1;
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
    end else begin
      addr_q <= addr_d;
      left_q <= left_d;
    end
  end

  assign addr         = addr_q;
  assign last_word    = (left_q == '0);
  assign next_in_page = (addr_q[PB-1:0] != {PB{1'b1}});
endmodule

// File: rtl/apr_ce_budget.sv
// Counts chip-enable-low cycles and says whether one more page word fits.
module apr_ce_budget #(
  parameter int CW     = 12,
  parameter int T_PAGE = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          active,
  input  logic [CW-1:0] cfg_ce_max,
  output logic          page_fits
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   need;

  always_comb begin
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = CW'(1);
    end else if (active && (cnt_q != {CW{1'b1}})) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign need      = {1'b0, cnt_q} + (CW+1)'(T_PAGE);
  assign page_fits = (need <= {1'b0, cfg_ce_max});
endmodule

// File: rtl/apsram_page_reader.sv
module apsram_page_reader #(
  parameter int AW     = 23,
  parameter int DW     = 16,
  parameter int LW     = 8,
  parameter int CW     = 12,
  parameter int PB     = 4,
  parameter int T_RAND = 7,
  parameter int T_PAGE = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_ce_max,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_words_m1,
  input  logic          req_page_en,
  output logic          rd_valid,
  output logic          rd_last,
  output logic [DW-1:0] rd_data,
  output logic          mem_ce_n,
  output logic          mem_adv_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [1:0]    mem_bw_n,
  output logic          mem_clk,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_dq_in,
  input  logic          mem_wait
);
  import apr_pkg::*;

  logic       rst_sync_n;
  apr_state_e state_q, state_d;
  logic       pen_q, pen_d;
  logic       load, step, start_rand, start_page, sample;
  logic       expire, last_word, next_in_page, page_fits, ce_low;
  logic       unused_wait;

  logic          rd_valid_q, rd_last_q;
  logic [DW-1:0] rd_data_q;

  assign unused_wait = mem_wait;

  apr_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  apr_interval_timer #(.T_RAND(T_RAND), .T_PAGE(T_PAGE)) u_timer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_rand (start_rand),
    .start_page (start_page),
    .expire     (expire)
  );

  apr_addr_gen #(.AW(AW), .LW(LW), .PB(PB)) u_addr (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .load         (load),
    .step         (step),
    .start_addr   (req_addr),
    .words_m1     (req_words_m1),
    .addr         (mem_addr),
    .last_word    (last_word),
    .next_in_page (next_in_page)
  );

  apr_ce_budget #(.CW(CW), .T_PAGE(T_PAGE)) u_budget (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .restart    (start_rand),
    .active     (ce_low),
    .cfg_ce_max (cfg_ce_max),
    .page_fits  (page_fits)
  );

  assign ce_low = (state_q == ST_RAND) || (state_q == ST_PAGE);

  // Next-state process
  always_comb begin
    state_d    = state_q;
    pen_d      = pen_q;
    load       = 1'b0;
    step       = 1'b0;
    start_rand = 1'b0;
    start_page = 1'b0;
    sample     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          load       = 1'b1;
          pen_d      = req_page_en;
          start_rand = 1'b1;
          state_d    = ST_RAND;
        end
      end
      ST_RAND, ST_PAGE: begin
        if (expire) begin
          sample = 1'b1;
          if (last_word) begin
            state_d = ST_IDLE;
          end else begin
            step = 1'b1;
            if (pen_q && next_in_page && page_fits) begin
              start_page = 1'b1;
              state_d    = ST_PAGE;
            end else begin
              state_d = ST_GAP;
            end
          end
        end
      end
      ST_GAP: begin
        start_rand = 1'b1;
        state_d    = ST_RAND;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q    <= ST_IDLE;
      pen_q      <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_last_q  <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      state_q    <= state_d;
      pen_q      <= pen_d;
      rd_valid_q <= sample;
      rd_last_q  <= sample && last_word;
      if (sample) rd_data_q <= mem_dq_in;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rd_valid  = rd_valid_q;
  assign rd_last   = rd_last_q;
  assign rd_data   = rd_data_q;
  assign mem_ce_n  = !ce_low;
  assign mem_adv_n = !ce_low;
  assign mem_oe_n  = !ce_low;
  assign mem_bw_n  = {2{!ce_low}};
  assign mem_we_n  = 1'b1;
  assign mem_clk   = 1'b0;
endmodule

// File: rtl/apr_checker.sv
module apr_checker #(
  parameter int AW     = 23,
  parameter int CW     = 12,
  parameter int PB     = 4,
  parameter int T_RAND = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cfg_ce_max,
  input logic          req_ready,
  input logic          rd_valid,
  input logic          rd_last,
  input logic          mem_ce_n,
  input logic          mem_adv_n,
  input logic          mem_oe_n,
  input logic [AW-1:0] mem_addr
);
  logic [CW:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_q <= '0;
    else if (!mem_ce_n) run_q <= run_q + 1'b1;
    else                run_q <= '0;
  end

  // R1: upper address bits fixed while chip enable stays low
  a_r1_page_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr[AW-1:PB]));

  // R5: strobes follow chip enable
  a_r5_adv_oe_with_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> (!mem_adv_n && !mem_oe_n));

  // R2: data is returned only after the memory was enabled
  a_r2_valid_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_ce_n));

  // R6: chip enable high and idle when the last word appears
  a_r6_ce_high_at_last: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> (mem_ce_n && req_ready));

  // R10: last only with valid
  a_r10_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);

  // R8: chip-enable-low run bounded
  a_r8_ce_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cfg_ce_max) >= T_RAND) |-> (run_q <= {1'b0, cfg_ce_max}));
endmodule

bind apsram_page_reader apr_checker #(
  .AW(AW), .CW(CW), .PB(PB), .T_RAND(T_RAND)
) u_apr_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cfg_ce_max (cfg_ce_max),
  .req_ready  (req_ready),
  .rd_valid   (rd_valid),
  .rd_last    (rd_last),
  .mem_ce_n   (mem_ce_n),
  .mem_adv_n  (mem_adv_n),
  .mem_oe_n   (mem_oe_n),
  .mem_addr   (mem_addr)
);

// File: tb/apsram_page_reader_test.sv
`timescale 1ns/1ps
module apsram_page_reader_test;
  localparam int AW = 23, DW = 16, LW = 8, CW = 12;
  localparam int TR = 7, TP = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cfg_ce_max;
  logic          req_valid, req_ready, req_page_en;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_words_m1;
  logic          rd_valid, rd_last;
  logic [DW-1:0] rd_data;
  logic          mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_clk;
  logic [1:0]    mem_bw_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq;
  logic          mem_wait;
  logic          wait_toggle;

  int n_checks = 0, n_fail = 0;
  int cyc = 0, acc = 0;
  int n_ev = 0;
  int ev_t [0:31];
  logic [DW-1:0] ev_d [0:31];
  logic          ev_l [0:31];
  int run_len = 0, max_run = 0, pin_bad = 0;

  always #5 clk = ~clk;

  apsram_page_reader #(.AW(AW), .DW(DW), .LW(LW), .CW(CW), .T_RAND(TR), .T_PAGE(TP)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_ce_max(cfg_ce_max),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_words_m1(req_words_m1), .req_page_en(req_page_en),
    .rd_valid(rd_valid), .rd_last(rd_last), .rd_data(rd_data),
    .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_bw_n(mem_bw_n), .mem_clk(mem_clk),
    .mem_addr(mem_addr), .mem_dq_in(mem_dq), .mem_wait(mem_wait)
  );

  function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
    return a[15:0] ^ 16'hA5C3;
  endfunction

  // memory responder
  assign mem_dq = (!mem_ce_n && !mem_oe_n) ? word_at(mem_addr) : 16'h0000;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (wait_toggle) mem_wait <= ~mem_wait;
  end

  // monitor, away from the active edge
  always @(negedge clk) begin
    if (rd_valid && n_ev < 32) begin
      ev_t[n_ev] = cyc - acc;
      ev_d[n_ev] = rd_data;
      ev_l[n_ev] = rd_last;
      n_ev = n_ev + 1;
    end
    if (!mem_ce_n) begin
      run_len = run_len + 1;
      if (run_len > max_run) max_run = run_len;
      if (mem_adv_n || mem_oe_n || mem_bw_n != 2'b00) pin_bad = pin_bad + 1;
    end else begin
      run_len = 0;
    end
    if (mem_we_n !== 1'b1 || mem_clk !== 1'b0) pin_bad = pin_bad + 1;
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Issue one request and wait until it has fully completed.
  task automatic issue(input logic [AW-1:0] a, input int m1, input bit pen);
    n_ev = 0; max_run = 0; pin_bad = 0;
    @(negedge clk);
    req_addr = a; req_words_m1 = LW'(m1); req_page_en = pen; req_valid = 1'b1;
    @(posedge clk); #1;
    acc = cyc;
    req_valid = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (n_ev >= m1 + 1 && req_ready) break;
    end
    repeat (3) @(negedge clk);
  endtask

  // Expected timeline from R2, R3, R4, R8, R9; data and last from R10.
  task automatic check_run(input string tag, input logic [AW-1:0] a, input int m1, input bit pen);
    int t, ce;
    logic [AW-1:0] cur;
    check(n_ev == m1 + 1, {tag, " R10 word count"}, n_ev, m1 + 1);
    t = TR; ce = TR; cur = a;
    for (int k = 0; k <= m1 && k < n_ev; k++) begin
      if (k > 0) begin
        if (pen && cur[3:0] != 4'hF && ce + TP <= int'(cfg_ce_max)) begin
          t = t + TP; ce = ce + TP;
        end else begin
          t = t + 1 + TR; ce = TR;
        end
        cur = cur + 1'b1;
      end
      check(ev_t[k] == t, {tag, " R2/R3/R4 capture cycle"}, ev_t[k], t);
      check(ev_d[k] == word_at(cur), {tag, " R10 data"}, int'(ev_d[k]), int'(word_at(cur)));
      check(ev_l[k] == (k == m1), {tag, " R10 last flag"}, int'(ev_l[k]), int'(k == m1));
    end
    check(pin_bad == 0, {tag, " R5 strobe levels"}, pin_bad, 0);
    check(max_run <= int'(cfg_ce_max), {tag, " R8 ce low run"}, max_run, int'(cfg_ce_max));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(mem_ce_n == 1'b1 && mem_oe_n == 1'b1, "R11 strobes in reset", int'(mem_ce_n), 1);
    check(rd_valid == 1'b0, "R11 rd_valid in reset", int'(rd_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready == 1'b1 && mem_ce_n == 1'b1, "R11 idle after reset", int'(req_ready), 1);
  endtask

  task automatic t_page_run();
    issue(23'h000100, 3, 1'b1);
    check_run("page run R1", 23'h000100, 3, 1'b1);
    check(ev_t[1] - ev_t[0] == TP, "R3 page spacing", ev_t[1] - ev_t[0], TP);
    check(ev_t[0] == TR, "R2 first word", ev_t[0], TR);
    check(mem_ce_n == 1'b1 && req_ready == 1'b1, "R6 idle after last", int'(mem_ce_n), 1);
  endtask

  task automatic t_cross();
    issue(23'h00001E, 4, 1'b1);
    check_run("page cross", 23'h00001E, 4, 1'b1);
    check(ev_t[2] - ev_t[1] == TR + 1, "R9 split at page end", ev_t[2] - ev_t[1], TR + 1);
  endtask

  task automatic t_nopage();
    issue(23'h000040, 2, 1'b0);
    check_run("page off", 23'h000040, 2, 1'b0);
    check(ev_t[1] - ev_t[0] == TR + 1, "R4 random per word", ev_t[1] - ev_t[0], TR + 1);
  endtask

  task automatic t_ce_limit();
    cfg_ce_max = 12'd12;
    issue(23'h000200, 4, 1'b1);
    check_run("ce limit", 23'h000200, 4, 1'b1);
    check(ev_t[2] == 18, "R8 split by ceiling", ev_t[2], 18);
    check(max_run == 10, "R8 longest run", max_run, 10);
    cfg_ce_max = 12'd255;
  endtask

  task automatic t_wait_ignored();
    wait_toggle = 1'b1;
    issue(23'h000100, 3, 1'b1);
    wait_toggle = 1'b0;
    mem_wait = 1'b1;
    check_run("wait toggling R7", 23'h000100, 3, 1'b1);
  endtask

  task automatic t_single();
    issue(23'h00030F, 0, 1'b1);
    check_run("single word", 23'h00030F, 0, 1'b1);
    check(ev_l[0] == 1'b1, "R10 single last", int'(ev_l[0]), 1);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    cfg_ce_max = 12'd255;
    req_valid = 1'b0; req_addr = '0; req_words_m1 = '0; req_page_en = 1'b0;
    mem_wait = 1'b1; wait_toggle = 1'b0;
    t_reset();
    t_page_run();
    t_cross();
    t_nopage();
    t_ce_limit();
    t_wait_ignored();
    t_single();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule